// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is one channel of a general-purpose timer. A 16-bit counter advances on every cycle in which the count-enable tick is high and the channel is running. Four compare registers, labelled A to D, are checked against the counter. Each compare register drives one output pin. On a match the pin is driven low, driven high, toggled or left as it is. Each pin also has a level that it takes when counting starts. The counter either runs free through the whole 16-bit range or returns to zero after it matches register A. The channel can also stop itself on a match of A.

Software programs the channel through a simple write port. Sticky flags record compare matches, counter overflow and a forced-cutoff event. An interrupt line reports a match of A or an overflow. When two channels are coupled, a counter write can be forwarded to the partner channel, and the partner's forwarded write loads this counter. An optional remapping lets compare registers C and D act as a second compare point on pins A and B. A cutoff input floats every output pin until software acknowledges the event.

Top module: `occ_timer`

## Requirements
- R1: After reset the counter reads 0, the channel is stopped, every pin level, pin output enable and flag is 0, and irq_o is 0.
- R2: While running in free mode (control bit 2 = 0), each tick adds 1 to the counter. A tick at FFFFh wraps the counter to 0000h and sets flag bit 4 (overflow).
- R3: With control bit 2 = 1, a tick that finds the counter equal to compare A loads 0, so the count period is A+1 ticks. Any tick that finds the counter equal to compare register j sets flag bit j (A=0, B=1, C=2, D=3).
- R4: On a match, pin i applies the 2-bit action held in action-register bits [2i+1:2i]: 00 leaves the pin unchanged, 01 drives it low, 10 drives it high, 11 inverts it. The new level appears one clock after the matching tick.
- R5: A control write (address 0) with bit 0 = 1 while the channel is stopped starts it and loads every pin with its initial level from level-register (address 2) bits [3:0].
- R6: A control write with bit 0 = 0 stops the channel. Further ticks then change neither the counter nor any pin.
- R7: With control bit 1 = 1, a match of A stops the channel. The counter stays at the A value, and the pins keep the levels set by that match.
- R8: irq_o is high whenever flag bit 0 or flag bit 4 is set. Flags are sticky. A write to address 8 clears every flag whose data bit is 1. A flag event in the same cycle as its clear leaves the flag set.
- R9: With control bit 3 = 1, a counter write (address 3) raises sync_wr_o in the same cycle and presents the written value on sync_val_o. With bit 3 = 0, sync_wr_o stays low. A peer_ld_i pulse loads peer_val_i into the counter.
- R10: With control bit 4 = 1, a match of C applies pin 2's action field to pin 0, and a match of D applies pin 3's action field to pin 1. Pins 2 and 3 then keep their levels. If both registers paired on a pin match on the same tick, the match of A or B takes priority.
- R11: While cutoff_i is high, flag bit 5 is set. While flag bit 5 is set, all pin_oe_o bits are 0, and otherwise they follow level-register bits [7:4]. Counting carries on during a cutoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-source enable, one count per high cycle |
| cutoff_i | input | 1 | Forced output cutoff request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| peer_ld_i | input | 1 | Counter load forwarded from the partner channel |
| peer_val_i | input | 16 | Value forwarded from the partner channel |
| cnt_o | output | 16 | Current counter value |
| pin_o | output | 4 | Compare output levels for pins A to D |
| pin_oe_o | output | 4 | Output enables for the compare pins |
| flags_o | output | 6 | Sticky flags: matches of A to D, overflow, cutoff |
| irq_o | output | 1 | Interrupt request |
| sync_wr_o | output | 1 | Counter write forwarded to the partner channel |
| sync_val_o | output | 16 | Value forwarded to the partner channel |

## Verification
A wrong run bit or counter step shows up on cnt_o one clock after the affected tick. A wrong period or wrap position shows up within the A+1 ticks of one period. A wrong pin level latched at start or on a match shows up on pin_o one clock after the event, and it stays wrong until the next match or restart, because the pins hold their level. A flag that is lost or set by mistake stays visible on flags_o and irq_o until it is cleared, so checking after a run of ticks still catches it.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int NPIN  = 4;
  localparam int NCMP  = 4;
  localparam int F_OVF = NCMP;
  localparam int F_CUT = NCMP + 1;
  localparam int NFLAG = NCMP + 2;

  localparam int A_CTRL = 0;
  localparam int A_ACT  = 1;
  localparam int A_LVL  = 2;
  localparam int A_CNT  = 3;
  localparam int A_CMP0 = 4;
  localparam int A_FLAG = 8;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic                  remap;
    logic                  sync;
    logic                  clr_a;
    logic                  autostop;
    logic [NPIN-1:0][1:0]  act;
    logic [NPIN-1:0]       init;
    logic [NPIN-1:0]       oe_en;
  } cfg_t;
endpackage

// File: rtl/occ_regs.sv
module occ_regs
  import occ_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     stop_hit,
  output cfg_t                     cfg,
  output logic                     run,
  output logic                     start_load,
  output logic [NCMP-1:0][CW-1:0]  cmp
);
  cfg_t                    cfg_q, cfg_d;
  logic                    run_q, run_d;
  logic [NCMP-1:0][CW-1:0] cmp_q, cmp_d;
  logic                    ctrl_wr;
  logic                    reg_en;

  assign ctrl_wr = wr_en && (wr_addr == AW'(A_CTRL));
  assign reg_en  = wr_en | stop_hit;

  always_comb begin
    cfg_d = cfg_q;
    run_d = run_q;
    cmp_d = cmp_q;
    if (stop_hit) run_d = 1'b0;
    if (ctrl_wr) begin
      run_d          = wr_data[0];
      cfg_d.autostop = wr_data[1];
      cfg_d.clr_a    = wr_data[2];
      cfg_d.sync     = wr_data[3];
      cfg_d.remap    = wr_data[4];
    end
    if (wr_en && (wr_addr == AW'(A_ACT))) cfg_d.act = wr_data[2*NPIN-1:0];
    if (wr_en && (wr_addr == AW'(A_LVL))) begin
      cfg_d.init  = wr_data[NPIN-1:0];
      cfg_d.oe_en = wr_data[2*NPIN-1:NPIN];
    end
    for (int j = 0; j < NCMP; j++) begin
      if (wr_en && (wr_addr == AW'(A_CMP0 + j))) cmp_d[j] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
      cmp_q <= '0;
    end else if (reg_en) begin
      cfg_q <= cfg_d;
      run_q <= run_d;
      cmp_q <= cmp_d;
    end
  end

  assign start_load = ctrl_wr & wr_data[0] & ~run_q;
  assign cfg = cfg_q;
  assign run = run_q;
  assign cmp = cmp_q;

  // R7
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !ctrl_wr) |=> !run_q);
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          adv,
  input  logic          wrap,
  input  logic          hold,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = ld | adv;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (adv && !hold) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !hold && !wrap) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  // R6
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/occ_pin.sv
module occ_pin
  import occ_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       init,
  input  logic       evt,
  input  logic [1:0] act,
  output logic       lvl
);
  logic lvl_q, lvl_d;
  logic lvl_en;

  assign lvl_en = load | evt;

  always_comb begin
    lvl_d = lvl_q;
    if (load) lvl_d = init;
    else begin
      case (pin_act_e'(act))
        ACT_LOW:    lvl_d = 1'b0;
        ACT_HIGH:   lvl_d = 1'b1;
        ACT_TOGGLE: lvl_d = ~lvl_q;
        default:    lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !evt) |=> $stable(lvl_q));
endmodule

// File: rtl/occ_timer.sv
module occ_timer
  import occ_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cutoff_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CW-1:0]    wr_data_i,
  input  logic             peer_ld_i,
  input  logic [CW-1:0]    peer_val_i,
  output logic [CW-1:0]    cnt_o,
  output logic [NPIN-1:0]  pin_o,
  output logic [NPIN-1:0]  pin_oe_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o,
  output logic             sync_wr_o,
  output logic [CW-1:0]    sync_val_o
);
  localparam int HALF = NPIN / 2;

  logic [1:0]              rst_sync_q;
  logic                    rst_n;
  cfg_t                    cfg;
  logic                    run, start_load;
  logic [NCMP-1:0][CW-1:0] cmp;
  logic [CW-1:0]           cnt;
  logic                    adv, cnt_wr, ld, stop_hit, ovf_evt;
  logic [CW-1:0]           ld_val;
  logic [NCMP-1:0]         hit;
  logic [NPIN-1:0]         evt;
  logic [NPIN-1:0][1:0]    act_sel;
  logic [NFLAG-1:0]        flags_q, flags_d, flag_set, flag_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  occ_regs #(.CW(CW), .AW(AW)) i_regs (
    .clk(clk_i), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .stop_hit(stop_hit), .cfg(cfg), .run(run),
    .start_load(start_load), .cmp(cmp)
  );

  assign adv = run & tick_i;
  always_comb begin
    for (int j = 0; j < NCMP; j++) hit[j] = adv && (cnt == cmp[j]);
  end
  assign stop_hit = hit[0] & cfg.autostop;
  assign cnt_wr   = wr_en_i && (wr_addr_i == AW'(A_CNT));
  assign ld       = cnt_wr | peer_ld_i;
  assign ld_val   = cnt_wr ? wr_data_i : peer_val_i;
  assign ovf_evt  = adv && (&cnt) && !ld && !stop_hit;

  occ_counter #(.CW(CW)) i_counter (
    .clk(clk_i), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .adv(adv),
    .wrap(cfg.clr_a & hit[0]), .hold(stop_hit), .cnt(cnt)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i < HALF) begin : g_pair
      assign evt[i]     = hit[i] | (cfg.remap & hit[i+HALF]);
      assign act_sel[i] = hit[i] ? cfg.act[i] : cfg.act[i+HALF];
    end else begin : g_solo
      assign evt[i]     = ~cfg.remap & hit[i];
      assign act_sel[i] = cfg.act[i];
    end
    occ_pin i_pin (
      .clk(clk_i), .rst_n(rst_n), .load(start_load), .init(cfg.init[i]),
      .evt(evt[i]), .act(act_sel[i]), .lvl(pin_o[i])
    );
  end

  assign flag_set = {cutoff_i, ovf_evt, hit};
  assign flag_clr = (wr_en_i && (wr_addr_i == AW'(A_FLAG))) ? wr_data_i[NFLAG-1:0] : '0;

  always_comb flags_d = flag_set | (flags_q & ~flag_clr);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign cnt_o      = cnt;
  assign flags_o    = flags_q;
  assign irq_o      = flags_q[0] | flags_q[F_OVF];
  assign pin_oe_o   = cfg.oe_en & {NPIN{~flags_q[F_CUT]}};
  assign sync_wr_o  = cnt_wr & cfg.sync;
  assign sync_val_o = wr_data_i;

  // R11
  cutoff_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cutoff_i |=> (pin_oe_o == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr)));

  // R2
  ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv && (&cnt_o) && !ld && !cfg.autostop) |=> (flags_o[F_OVF] && cnt_o == '0));

  // R3
  clr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hit[0] && cfg.clr_a && !cfg.autostop && !ld) |=> (cnt_o == '0));
endmodule

// File: tb/test_occ_timer.sv
module test_occ_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cutoff = 1'b0, wr = 1'b0, peer_ld = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] data = '0, peer_val = '0;
  logic [15:0] cnt, sync_val;
  logic [3:0]  pin, oe;
  logic [5:0]  flags;
  logic        irq, sync_wr;
  int          errors = 0, checks = 0;
  bit          done = 0;
  logic [15:0] c0;

  always #2 clk = ~clk;

  occ_timer i_occ_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cutoff_i(cutoff),
    .wr_en_i(wr), .wr_addr_i(addr), .wr_data_i(data), .peer_ld_i(peer_ld),
    .peer_val_i(peer_val), .cnt_o(cnt), .pin_o(pin), .pin_oe_o(oe),
    .flags_o(flags), .irq_o(irq), .sync_wr_o(sync_wr), .sync_val_o(sync_val)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        clr;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_fa;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd4, 1'b1, 8'd5, 16'd0, 1'b1},
    '{16'd4, 1'b1, 8'd7, 16'd2, 1'b1},
    '{16'd4, 1'b0, 8'd7, 16'd7, 1'b1},
    '{16'd9, 1'b0, 8'd3, 16'd3, 1'b0},
    '{16'd0, 1'b1, 8'd3, 16'd0, 1'b1},
    '{16'd1, 1'b1, 8'd3, 16'd1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; data = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 pins", 32'(pin), 0);
    chk("R1 oe", 32'(oe), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 / R2 vector table: period and match flag
    foreach (VECS[k]) begin
      wr_reg(4'd0, {13'd0, VECS[k].clr, 2'b00});
      wr_reg(4'd4, VECS[k].a);
      wr_reg(4'd3, 16'd0);
      wr_reg(4'd8, 16'h3F);
      wr_reg(4'd0, {13'd0, VECS[k].clr, 2'b01});
      ticks(VECS[k].n);
      chk($sformatf("R3 vec%0d cnt", k), 32'(cnt), 32'(VECS[k].exp_cnt));
      chk($sformatf("R3 vec%0d flagA", k), 32'(flags[0]), 32'(VECS[k].exp_fa));
    end

    // R4 / R5 pin actions and initial levels
    wr_reg(4'd0, 16'h0);
    wr_reg(4'd1, 16'h001B);
    wr_reg(4'd2, 16'h00FC);
    for (int j = 4; j < 8; j++) wr_reg(4'(j), 16'd2);
    wr_reg(4'd3, 16'd0);
    wr_reg(4'd0, 16'h1);
    chk("R5 init levels", 32'(pin), 32'hC);
    ticks(2);
    chk("R4 before match", 32'(pin), 32'hC);
    ticks(1);
    chk("R4 after match", 32'(pin), 32'hB);
    chk("R2 count", 32'(cnt), 3);

    // R6 software stop
    wr_reg(4'd0, 16'h0);
    ticks(4);
    chk("R6 cnt hold", 32'(cnt), 3);
    chk("R6 pin hold", 32'(pin), 32'hB);
    wr_reg(4'd0, 16'h1);
    chk("R5 restart reload", 32'(pin), 32'hC);
    wr_reg(4'd0, 16'h0);

    // R7 auto stop at match A
    wr_reg(4'd4, 16'd3);
    wr_reg(4'd3, 16'd0);
    wr_reg(4'd8, 16'h3F);
    wr_reg(4'd0, 16'h7);
    ticks(10);
    chk("R7 cnt held at A", 32'(cnt), 3);
    chk("R7 pins after match", 32'(pin), 32'hB);
    chk("R8 irq on match A", 32'(irq), 1);

    // R2 overflow, R8 flags
    wr_reg(4'd0, 16'h0);
    wr_reg(4'd8, 16'h3F);
    wr_reg(4'd3, 16'hFFFE);
    wr_reg(4'd0, 16'h1);
    ticks(2);
    chk("R2 wrap", 32'(cnt), 0);
    chk("R2 ovf flag", 32'(flags[4]), 1);
    chk("R8 irq on ovf", 32'(irq), 1);
    wr_reg(4'd8, 16'h10);
    chk("R8 w1c flags", 32'(flags), 0);
    chk("R8 irq cleared", 32'(irq), 0);
    wr_reg(4'd3, 16'hFFFF);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 4'd8; data = 16'h10;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk("R8 set wins over clear", 32'(flags[4]), 1);
    chk("R2 wrap with clear", 32'(cnt), 0);

    // R9 coupling
    wr_reg(4'd0, 16'h9);
    @(negedge clk); wr = 1'b1; addr = 4'd3; data = 16'h1234;
    #1;
    chk("R9 sync strobe", 32'(sync_wr), 1);
    chk("R9 sync value", 32'(sync_val), 32'h1234);
    @(negedge clk); wr = 1'b0;
    chk("R9 local load", 32'(cnt), 32'h1234);
    wr_reg(4'd0, 16'h1);
    @(negedge clk); wr = 1'b1; addr = 4'd3; data = 16'h0055;
    #1;
    chk("R9 no strobe when uncoupled", 32'(sync_wr), 0);
    @(negedge clk); wr = 1'b0;
    @(negedge clk); peer_ld = 1'b1; peer_val = 16'hABCD;
    @(negedge clk); peer_ld = 1'b0;
    chk("R9 peer load", 32'(cnt), 32'hABCD);

    // R10 remap of C onto pin A
    wr_reg(4'd0, 16'h0);
    wr_reg(4'd1, 16'h0030);
    wr_reg(4'd2, 16'h00F0);
    wr_reg(4'd4, 16'd5);
    wr_reg(4'd6, 16'd1);
    wr_reg(4'd3, 16'd0);
    wr_reg(4'd0, 16'h11);
    ticks(2);
    chk("R10 remapped pins", 32'(pin), 32'h1);

    // R11 cutoff
    chk("R11 oe normal", 32'(oe), 32'hF);
    @(negedge clk); cutoff = 1'b1;
    @(negedge clk); cutoff = 1'b0;
    chk("R11 oe cut", 32'(oe), 0);
    chk("R11 cut flag", 32'(flags[5]), 1);
    c0 = cnt;
    ticks(3);
    chk("R11 counting continues", 32'(cnt), 32'(c0 + 16'd3));
    chk("R11 oe latched", 32'(oe), 0);
    wr_reg(4'd8, 16'h20);
    chk("R11 oe restored", 32'(oe), 32'hF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule